// File: doc/BRIEF.md
# Frame-Buffer Pixel Unpacker

This block walks a frame held in byte-wide display memory and turns it into a raster-ordered stream of palette indices. Each index leaves the block zero-extended to 8 bits on a valid/ready handshake, together with a start-of-frame flag and an end-of-line flag. A start pulse latches the frame configuration: the pixel format code, the base byte address, the byte distance between the starts of consecutive lines, the line width in pixels and the number of lines.

Four layouts are decoded. Two of them pack several pixels into one byte, starting from the least significant bits. The other two hold one pixel per byte, and the unused upper bits are forced to zero. The block issues one byte read at a time on a synchronous read port with one cycle of latency. It captures the returned byte, hands out that byte's pixels, and only then fetches the next byte. Palette lookup, display timing and bus arbitration are left to neighbouring logic.

Top module: `pix_unpack_top`

## Requirements
- R1: After reset, `pix_valid`, `mem_rd_en`, `busy` and `fmt_err` are all 0.
- R2: The first byte read of a frame is at the base address. Line n reads ascending consecutive bytes starting at base + n × stride.
- R3: Format code 0 (2 bits per pixel, four per byte) emits bits 1:0, then 3:2, then 5:4, then 7:6 of each byte.
- R4: Format code 1 (4 bits per pixel, two per byte) emits bits 3:0 first and then bits 7:4.
- R5: Format code 2 (one 4-bit pixel per byte) emits bits 3:0 with output bits 7:4 at zero, whatever memory holds there. No format ever drives output bits 7:5 high.
- R6: Format code 3 (one 5-bit pixel per byte) emits bits 4:0 with output bits 7:5 at zero, whatever memory holds there.
- R7: When the width is not a multiple of the pixels per byte, the unused pixels of a line's last byte are dropped. Exactly width × lines pixels are emitted, and each line reads ceil(width / pixels-per-byte) bytes.
- R8: `pix_sof` is high only on the first pixel after a start. `pix_eol` is high exactly on the last pixel of every line.
- R9: While `pix_valid` is high and `pix_ready` is low, the pixel and its flags hold steady and no read is issued. `mem_rd_en` is never high on two consecutive cycles.
- R10: A start with format code 4 to 7 emits no pixels and issues no reads. It sets `fmt_err`, which stays set until reset.
- R11: The configuration is sampled only at an accepted start. Changes to the configuration inputs and further start pulses during a frame have no effect on that frame.
- R12: A start with width 0 or line count 0 emits no pixels, issues no reads and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame with the present configuration (taken only when idle) |
| cfg_fmt | input | 3 | Pixel format code 0..3. Other values are invalid |
| cfg_base | input | ADDR_W | Byte address of the top-left pixel |
| cfg_stride | input | ADDR_W | Byte distance between line starts |
| cfg_width | input | WIDTH_W | Pixels per line |
| cfg_lines | input | LINES_W | Lines per frame |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 8 | Zero-extended palette index |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of a line |
| busy | output | 1 | Frame in progress |
| fmt_err | output | 1 | Sticky invalid-format flag |

## Verification
A read request is raised in the cycle after an accepted start, and also in the cycle after the handshake that consumes a byte's last pixel. The byte comes back one edge later and is registered at the next edge, so the first pixel of that byte is valid two cycles after its request. Further pixels of the same byte follow in the cycle after each handshake. The bench drives and samples only on the falling clock edge. It compares read addresses when `mem_rd_en` is seen high, compares pixels only in cycles where valid and ready are both high, and checks held values in the cycle after a refused pixel. Its expected byte addresses and pixels are worked out from the latched configuration and its own memory image.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int PIX_W  = 8;
    localparam int SLOT_W = 2;
    localparam int SLOTS  = 1 << SLOT_W;

    typedef enum logic [2:0] {
        FMT_PK2 = 3'd0,
        FMT_PK4 = 3'd1,
        FMT_UN4 = 3'd2,
        FMT_UN5 = 3'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_CAP,
        ST_EMIT
    } seq_st_e;

    typedef struct packed {
        logic [PIX_W-1:0] data;
        logic             sof;
        logic             eol;
    } pix_beat_t;

    function automatic logic fmt_supported(input logic [2:0] code);
        return code <= 3'd3;
    endfunction

    // index of the final pixel slot inside one byte
    function automatic logic [SLOT_W-1:0] last_slot(input logic [2:0] code);
        case (code)
            FMT_PK2: return SLOT_W'(3);
            FMT_PK4: return SLOT_W'(1);
            default: return SLOT_W'(0);
        endcase
    endfunction

    // pull one pixel out of a byte, zero-extended, unused bits dropped
    function automatic logic [PIX_W-1:0] pick(input logic [2:0] code,
                                              input logic [7:0] b,
                                              input logic [SLOT_W-1:0] slot);
        logic [PIX_W-1:0] r;
        r = '0;
        case (code)
            FMT_PK2: r[1:0] = b[{slot, 1'b0} +: 2];
            FMT_PK4: r[3:0] = slot[0] ? b[7:4] : b[3:0];
            FMT_UN4: r[3:0] = b[3:0];
            FMT_UN5: r[4:0] = b[4:0];
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxu_addr_walk.sv
module pxu_addr_walk #(
    parameter int ADDR_W  = 16,
    parameter int LINES_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  stride,
    input  logic [LINES_W-1:0] lines,
    input  logic               step_byte,
    input  logic               step_line,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               last_line
);
    logic [ADDR_W-1:0]  line_start;
    logic [ADDR_W-1:0]  stride_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LINES_W-1:0] line_idx;
    logic [LINES_W-1:0] lines_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_start <= '0;
            stride_q   <= '0;
            cur_addr   <= '0;
            line_idx   <= '0;
            lines_q    <= '0;
        end else if (load) begin
            line_start <= base;
            stride_q   <= stride;
            cur_addr   <= base;
            line_idx   <= '0;
            lines_q    <= lines;
        end else if (step_line) begin
            line_start <= line_start + stride_q;
            cur_addr   <= line_start + stride_q;
            line_idx   <= line_idx + LINES_W'(1);
        end else if (step_byte) begin
            cur_addr   <= cur_addr + ADDR_W'(1);
        end
    end

    assign rd_addr   = cur_addr;
    assign last_line = (line_idx == lines_q - LINES_W'(1));

    AST_BYTE_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (step_byte && !step_line && !load) |=> (rd_addr == $past(rd_addr) + ADDR_W'(1))) // R2
        else $error("byte address did not advance by one");

    AST_LOAD_AT_BASE: assert property (@(posedge clk) disable iff (rst)
        load |=> (rd_addr == $past(base))) // R2
        else $error("frame did not begin at base");

endmodule

// File: rtl/pxu_lane_sel.sv
module pxu_lane_sel
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [7:0]        rd_data,
    input  logic [2:0]        fmt,
    input  logic [SLOT_W-1:0] slot,
    output logic [PIX_W-1:0]  pix
);
    logic [7:0]       byte_q;
    logic [PIX_W-1:0] cand [SLOTS];

    always_ff @(posedge clk) begin
        if (rst)         byte_q <= '0;
        else if (cap_en) byte_q <= rd_data;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign cand[g] = pick(fmt, byte_q, SLOT_W'(g));
    end

    assign pix = cand[slot];

    AST_UN4_MASKED: assert property (@(posedge clk) disable iff (rst)
        (fmt == 3'd2) |-> (pix[7:4] == 4'd0)) // R5
        else $error("unused bits leaked in 4-bit unpacked mode");

endmodule

// File: rtl/pxu_seq.sv
module pxu_seq
    import pxu_pkg::*;
#(
    parameter int WIDTH_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [2:0]         cfg_fmt,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               cfg_lines_zero,
    input  logic               last_line,
    input  logic               pix_ready,
    output logic               mem_rd_en,
    output logic               cap_en,
    output logic               load,
    output logic               step_byte,
    output logic               step_line,
    output logic               pix_valid,
    output logic               sof,
    output logic               eol,
    output logic [SLOT_W-1:0]  slot,
    output logic [2:0]         fmt_q,
    output logic               busy,
    output logic               fmt_err
);
    seq_st_e            st;
    logic [WIDTH_W-1:0] width_q;
    logic [WIDTH_W-1:0] x_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               first_q;
    logic               err_q;
    logic               fire;
    logic               line_end;
    logic               byte_end;

    assign fire     = (st == ST_EMIT) && pix_ready;
    assign line_end = (x_q == width_q - WIDTH_W'(1));
    assign byte_end = (slot_q == last_slot(fmt_q));

    assign load      = (st == ST_IDLE) && start && fmt_supported(cfg_fmt)
                       && (cfg_width != '0) && !cfg_lines_zero;
    assign step_line = fire && line_end && !last_line;
    assign step_byte = fire && !line_end && byte_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            fmt_q   <= '0;
            width_q <= '0;
            x_q     <= '0;
            slot_q  <= '0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start && !fmt_supported(cfg_fmt)) begin
                        err_q <= 1'b1;
                    end else if (load) begin
                        fmt_q   <= cfg_fmt;
                        width_q <= cfg_width;
                        x_q     <= '0;
                        slot_q  <= '0;
                        first_q <= 1'b1;
                        st      <= ST_RD;
                    end
                end
                ST_RD:  st <= ST_CAP;
                ST_CAP: st <= ST_EMIT;
                ST_EMIT: begin
                    if (pix_ready) begin
                        first_q <= 1'b0;
                        if (line_end) begin
                            x_q    <= '0;
                            slot_q <= '0;
                            st     <= last_line ? ST_IDLE : ST_RD;
                        end else if (byte_end) begin
                            x_q    <= x_q + WIDTH_W'(1);
                            slot_q <= '0;
                            st     <= ST_RD;
                        end else begin
                            x_q    <= x_q + WIDTH_W'(1);
                            slot_q <= slot_q + SLOT_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en = (st == ST_RD);
    assign cap_en    = (st == ST_CAP);
    assign pix_valid = (st == ST_EMIT);
    assign sof       = pix_valid && first_q;
    assign eol       = pix_valid && line_end;
    assign slot      = slot_q;
    assign busy      = (st != ST_IDLE);
    assign fmt_err   = err_q;

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en) // R9
        else $error("back-to-back reads");

    AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |=> (pix_valid && !mem_rd_en)) // R9
        else $error("fetch while stalled");

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        fmt_err |=> fmt_err) // R10
        else $error("error flag cleared");

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (sof && pix_ready) |=> !sof) // R8
        else $error("start-of-frame repeated");

endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
    import pxu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WIDTH_W = 10,
    parameter int LINES_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [2:0]         cfg_fmt,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [ADDR_W-1:0]  cfg_stride,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [LINES_W-1:0] cfg_lines,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [7:0]         mem_rd_data,
    output logic               pix_valid,
    input  logic               pix_ready,
    output logic [7:0]         pix_data,
    output logic               pix_sof,
    output logic               pix_eol,
    output logic               busy,
    output logic               fmt_err
);
    logic              cap_en;
    logic              load;
    logic              step_byte;
    logic              step_line;
    logic              last_line;
    logic              sof_w;
    logic              eol_w;
    logic              valid_w;
    logic [SLOT_W-1:0] slot;
    logic [2:0]        fmt_q;
    logic [PIX_W-1:0]  lane_pix;
    pix_beat_t         beat;

    pxu_seq #(.WIDTH_W(WIDTH_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .cfg_fmt        (cfg_fmt),
        .cfg_width      (cfg_width),
        .cfg_lines_zero (cfg_lines == '0),
        .last_line      (last_line),
        .pix_ready      (pix_ready),
        .mem_rd_en      (mem_rd_en),
        .cap_en         (cap_en),
        .load           (load),
        .step_byte      (step_byte),
        .step_line      (step_line),
        .pix_valid      (valid_w),
        .sof            (sof_w),
        .eol            (eol_w),
        .slot           (slot),
        .fmt_q          (fmt_q),
        .busy           (busy),
        .fmt_err        (fmt_err)
    );

    pxu_addr_walk #(.ADDR_W(ADDR_W), .LINES_W(LINES_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .base      (cfg_base),
        .stride    (cfg_stride),
        .lines     (cfg_lines),
        .step_byte (step_byte),
        .step_line (step_line),
        .rd_addr   (mem_addr),
        .last_line (last_line)
    );

    pxu_lane_sel u_lane (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .rd_data (mem_rd_data),
        .fmt     (fmt_q),
        .slot    (slot),
        .pix     (lane_pix)
    );

    assign beat      = '{data: lane_pix, sof: sof_w, eol: eol_w};
    assign pix_valid = valid_w;
    assign pix_data  = beat.data;
    assign pix_sof   = beat.sof;
    assign pix_eol   = beat.eol;

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)
                                       && $stable(pix_eol) && $stable(pix_sof))) // R9
        else $error("pixel changed while stalled");

    AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix_data[7:5] == 3'd0)) // R6
        else $error("upper pixel bits not masked");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd_en && !pix_valid)) // R12
        else $error("activity while idle");

endmodule

// File: tb/pix_unpack_top_tb.sv
module pix_unpack_top_tb;

    typedef struct packed {
        logic [2:0] fmt;
        logic [7:0] base;
        logic [7:0] stride;
        logic [7:0] width;
        logic [3:0] lines;
        logic       stall;
        logic       chg;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h10, 8'h08, 8'd9, 4'd3, 1'b0, 1'b0},
        '{3'd1, 8'h40, 8'h06, 8'd5, 4'd2, 1'b1, 1'b0},
        '{3'd2, 8'h80, 8'h0A, 8'd4, 4'd3, 1'b0, 1'b1},
        '{3'd3, 8'hA0, 8'h05, 8'd3, 4'd4, 1'b1, 1'b0},
        '{3'd0, 8'h00, 8'h01, 8'd4, 4'd2, 1'b1, 1'b1},
        '{3'd1, 8'hC0, 8'h10, 8'd1, 4'd1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cfg_fmt = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_stride = '0;
    logic [9:0]  cfg_width = '0;
    logic [7:0]  cfg_lines = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [7:0]  pix_data;
    logic        pix_sof;
    logic        pix_eol;
    logic        busy;
    logic        fmt_err;
    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[7:0]];

    pix_unpack_top u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_fmt(cfg_fmt),
        .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_width(cfg_width),
        .cfg_lines(cfg_lines), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .pix_sof(pix_sof), .pix_eol(pix_eol),
        .busy(busy), .fmt_err(fmt_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ppb(input logic [2:0] f);
        return (f == 3'd0) ? 4 : (f == 3'd1) ? 2 : 1;
    endfunction

    function automatic int bpp(input logic [2:0] f);
        return (f == 3'd0) ? 2 : (f == 3'd3) ? 5 : 4;
    endfunction

    function automatic string fmt_req(input logic [2:0] f);
        case (f)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // run one frame from the table, checking addresses, pixels and flags
    task automatic run_frame(input vec_t v);
        int   per    = ppb(v.fmt);
        int   nb     = (int'(v.width) + per - 1) / per;
        int   exp_n  = int'(v.width) * int'(v.lines);
        int   npix   = 0;
        int   k      = 0;
        logic prev_rd = 1'b0;
        logic held    = 1'b0;
        logic [7:0] held_data = '0;
        logic chg_done = 1'b0;
        @(negedge clk);
        cfg_fmt = v.fmt; cfg_base = 16'(v.base); cfg_stride = 16'(v.stride);
        cfg_width = 10'(v.width); cfg_lines = 8'(v.lines);
        start = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (v.chg && npix == 2 && !chg_done) begin
                // R11: mid-frame edits and a second start must be ignored
                cfg_fmt = 3'd3; cfg_stride = 16'h33; cfg_width = 10'd7;
                cfg_lines = 8'd9; cfg_base = 16'h05; start = 1'b1;
                chg_done = 1'b1;
            end
            if (held) begin
                chk("R9", "held valid", 32'(pix_valid), 32'd1);
                chk("R9", "held data", 32'(pix_data), 32'(held_data));
            end
            if (mem_rd_en) begin
                int ln = k / nb;
                int bi = k % nb;
                chk("R2", "read address", 32'(mem_addr),
                    32'(int'(v.base) + ln * int'(v.stride) + bi));
                if (prev_rd) chk("R9", "back-to-back read", 32'd1, 32'd0);
                if (pix_valid && held) chk("R9", "read while stalled", 32'd1, 32'd0);
                k++;
            end
            prev_rd   = mem_rd_en;
            pix_ready = v.stall ? ((cyc % 3) != 0) : 1'b1;
            held      = pix_valid && !pix_ready;
            held_data = pix_data;
            if (pix_valid && pix_ready) begin
                if (npix < exp_n) begin
                    int ln  = npix / int'(v.width);
                    int x   = npix % int'(v.width);
                    int adr = int'(v.base) + ln * int'(v.stride) + x / per;
                    int sh  = (x % per) * bpp(v.fmt);
                    logic [7:0] b = mem[adr[7:0]];
                    logic [7:0] e = 8'((b >> sh) & ((1 << bpp(v.fmt)) - 1));
                    chk(fmt_req(v.fmt), "pixel", 32'(pix_data), 32'(e));
                    chk("R8", "sof/eol", {30'd0, pix_sof, pix_eol},
                        {30'd0, npix == 0, x == int'(v.width) - 1});
                end else begin
                    chk("R7", "extra pixel", 32'd1, 32'd0);
                end
                npix++;
            end
            if (npix >= exp_n && !busy && !start) break;
        end
        pix_ready = 1'b0;
        chk("R7", "pixel count", 32'(npix), 32'(exp_n));
        chk("R7", "byte reads", 32'(k), 32'(nb * int'(v.lines)));
    endtask

    // start with given config and watch that nothing happens
    task automatic quiet_start(input logic [2:0] f, input logic [9:0] w,
                               input logic [7:0] l, input string req);
        int nv = 0;
        int nr = 0;
        @(negedge clk);
        cfg_fmt = f; cfg_base = 16'h20; cfg_stride = 16'h4;
        cfg_width = w; cfg_lines = l; start = 1'b1; pix_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (pix_valid) nv++;
            if (mem_rd_en) nr++;
        end
        pix_ready = 1'b0;
        chk(req, "pixels after start", 32'(nv), 32'd0);
        chk(req, "reads after start", 32'(nr), 32'd0);
        chk(req, "busy", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "pix_valid", 32'(pix_valid), 32'd0);
        chk("R1", "mem_rd_en", 32'(mem_rd_en), 32'd0);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "fmt_err", 32'(fmt_err), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_frame(VECS[i]);

        // R12: empty frames
        quiet_start(3'd1, 10'd0, 8'd3, "R12");
        quiet_start(3'd0, 10'd8, 8'd0, "R12");
        chk("R12", "no error on empty frame", 32'(fmt_err), 32'd0);

        // R10: invalid format codes
        quiet_start(3'd5, 10'd4, 8'd2, "R10");
        chk("R10", "fmt_err set", 32'(fmt_err), 32'd1);
        quiet_start(3'd7, 10'd4, 8'd2, "R10");
        run_frame(VECS[3]);
        chk("R10", "fmt_err sticky", 32'(fmt_err), 32'd1);

        // R1: reset clears the sticky flag
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "fmt_err after reset", 32'(fmt_err), 32'd0);
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule